// File: doc/BRIEF.md
# USB OTG Register Front-End

This block is the bus-facing register front-end placed ahead of a USB On-The-Go controller core. Every bus access names a 12-bit byte offset inside the block's window, an access size (byte, half-word or word), a direction and write data. The block decides where the access lands. Low offsets go straight to the core's register port. A middle band reaches the core through a compressing address remap. Offsets from 0x400 up belong to a small bank of local registers. These cover a revision word, a system configuration word with a self-clearing soft reset, a fixed status word, an interface select field, a simulation enable bit and a forced standby bit.

Reads return data in the same cycle, from the core port or from the local bank. Accesses the bank cannot honour raise a one-cycle error flag. The core's interrupt level is forwarded to the controller interrupt output without change.

Top module: `usb_otg_regfront`

## Requirements
- R1: With bus_sel high and an offset in 0x000-0x1FF, core_sel is high in the same cycle. core_addr equals the offset, and core_wr, core_size and core_wdata equal the bus values. bus_rdata returns core_rdata and bus_err stays low.
- R2: With bus_sel high and an offset in 0x200-0x3FF, core_sel is high and core_addr equals 0x20 plus 4 times ((offset / 32) mod 16), so it lies between 0x20 and 0x5C. All other fields are forwarded as in R1.
- R3: An offset at or above 0x400 never asserts core_sel.
- R4: A word read (size code 2) at 0x400 returns the REV_VALUE parameter, and one at 0x408 returns 0x00000001. A word write to either offset changes nothing and raises bus_err.
- R5: A word write at 0x404 stores the write data ANDed with 0x301D, so bit 1 is never kept. Word reads at 0x404 return the stored value.
- R6: Word writes keep only bits [1:0] at 0x40C, only bit 0 at 0x410 and only bit 0 at 0x414. All other bits read as zero.
- R7: A word write at 0x404 with data bit 1 set clears the registers at 0x40C, 0x410 and 0x414 from the next cycle. The configuration register takes the new masked value.
- R8: Any access at or above 0x400 whose offset is not one of 0x400, 0x404, 0x408, 0x40C, 0x410 or 0x414 raises bus_err, reads as zero and changes no register.
- R9: A byte (size code 0) or half-word (size code 1) access to a listed register at or above 0x400 raises bus_err, reads as zero and changes no register.
- R10: ctl_irq follows core_irq in the same cycle.
- R11: After rst_n is released, the registers at 0x404, 0x40C, 0x410 and 0x414 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Size code: 0 byte, 1 half, 2 word |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Access rejected or read-only write |
| core_sel | output | 1 | Core register access valid |
| core_wr | output | 1 | Core write strobe qualifier |
| core_size | output | 2 | Size code forwarded to the core |
| core_addr | output | 9 | Core register offset |
| core_wdata | output | 32 | Core write data |
| core_rdata | input | 32 | Core read data, same cycle |
| core_irq | input | 1 | Core interrupt request level |
| ctl_irq | output | 1 | Controller interrupt output |

## Verification
The bench builds the block with REV_VALUE set to 0xA5A50102 in place of the default. This makes a revision read distinguishable from zero, from the status word and from any core data. The core is a bench model that returns a tag combined with the offset it receives. Each read therefore shows which core offset the remap produced. Sweeping the remap band across all sixteen 32-byte steps reaches both ends of the 0x20-0x5C range.

// File: rtl/usb_otg_pkg.sv
package usb_otg_pkg;
  localparam int BUS_AW   = 12;
  localparam int CORE_AW  = 9;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 3;
  localparam int NUM_REGS = 6;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [IDX_W-1:0] IX_REV  = 3'd0;
  localparam logic [IDX_W-1:0] IX_CFG  = 3'd1;
  localparam logic [IDX_W-1:0] IX_STAT = 3'd2;
  localparam logic [IDX_W-1:0] IX_IFS  = 3'd3;
  localparam logic [IDX_W-1:0] IX_SIM  = 3'd4;
  localparam logic [IDX_W-1:0] IX_STBY = 3'd5;

  localparam logic [DATA_W-1:0] CFG_KEEP = 32'h0000_301D;
  localparam logic [DATA_W-1:0] STAT_VAL = 32'h0000_0001;

  typedef enum logic [1:0] {RG_DIRECT, RG_REMAP, RG_LOCAL} region_e;

  function automatic region_e region_of(input logic [BUS_AW-1:0] a);
    if (a[BUS_AW-1:BUS_AW-2] != 2'b00) return RG_LOCAL;
    if (a[BUS_AW-3]) return RG_REMAP;
    return RG_DIRECT;
  endfunction

  // 0x20 + ((a >> 3) & 0x3C): keeps offset bits [8:5] as a word index
  function automatic logic [CORE_AW-1:0] remap_off(input logic [BUS_AW-1:0] a);
    logic [CORE_AW-1:0] shifted;
    shifted = CORE_AW'(a >> 3);
    return CORE_AW'(9'h020) + (shifted & CORE_AW'(9'h03C));
  endfunction

  function automatic logic ro_index(input logic [IDX_W-1:0] ix);
    return (ix == IX_REV) || (ix == IX_STAT);
  endfunction
endpackage

// File: rtl/otg_addr_decode.sv
module otg_addr_decode
  import usb_otg_pkg::*;
(
  input  logic [BUS_AW-1:0] addr,
  output region_e           region,
  output logic              reg_hit,
  output logic [IDX_W-1:0]  reg_idx
);
  localparam logic [BUS_AW-6:0] BANK_TAG = 7'h20;

  always_comb begin
    region  = region_of(addr);
    reg_idx = addr[IDX_W+1:2];
    reg_hit = (addr[BUS_AW-1:5] == BANK_TAG) && (addr[1:0] == 2'b00) &&
              (int'(reg_idx) < NUM_REGS);
  end
endmodule

// File: rtl/otg_wrap_regs.sv
module otg_wrap_regs
  import usb_otg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cfg_q,
  output logic [1:0]        ifsel_q,
  output logic              sim_q,
  output logic              stdby_q,
  output logic              soft_rst_evt
);
  assign soft_rst_evt = wr_en && (wr_idx == IX_CFG) && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ifsel_q <= '0;
      sim_q   <= 1'b0;
      stdby_q <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_idx)
        IX_CFG: begin
          cfg_q <= wr_data & CFG_KEEP;
          if (wr_data[1]) begin
            ifsel_q <= '0;
            sim_q   <= 1'b0;
            stdby_q <= 1'b0;
          end
        end
        IX_IFS:  ifsel_q <= wr_data[1:0];
        IX_SIM:  sim_q   <= wr_data[0];
        IX_STBY: stdby_q <= wr_data[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/usb_otg_regfront.sv
module usb_otg_regfront
  import usb_otg_pkg::*;
#(
  parameter logic [31:0] REV_VALUE = 32'h0000_0033
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [1:0]         bus_size,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  output logic               core_sel,
  output logic               core_wr,
  output logic [1:0]         core_size,
  output logic [CORE_AW-1:0] core_addr,
  output logic [DATA_W-1:0]  core_wdata,
  input  logic [DATA_W-1:0]  core_rdata,
  input  logic               core_irq,
  output logic               ctl_irq
);
  region_e           region;
  logic              reg_hit;
  logic [IDX_W-1:0]  reg_idx;
  logic              local_ok;
  logic              local_wr;
  logic              ro_wr_evt;
  logic              soft_rst_evt;
  logic [DATA_W-1:0] cfg_q;
  logic [1:0]        ifsel_q;
  logic              sim_q;
  logic              stdby_q;
  logic [DATA_W-1:0] local_rdata;

  otg_addr_decode u_dec (
    .addr    (bus_addr),
    .region  (region),
    .reg_hit (reg_hit),
    .reg_idx (reg_idx)
  );

  assign local_ok  = bus_sel && (region == RG_LOCAL) && reg_hit && (bus_size == SZ_WORD);
  assign ro_wr_evt = local_ok && bus_wr && ro_index(reg_idx);
  assign local_wr  = local_ok && bus_wr && !ro_index(reg_idx);

  otg_wrap_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (local_wr),
    .wr_idx       (reg_idx),
    .wr_data      (bus_wdata),
    .cfg_q        (cfg_q),
    .ifsel_q      (ifsel_q),
    .sim_q        (sim_q),
    .stdby_q      (stdby_q),
    .soft_rst_evt (soft_rst_evt)
  );

  always_comb begin
    unique case (reg_idx)
      IX_REV:  local_rdata = REV_VALUE;
      IX_CFG:  local_rdata = cfg_q;
      IX_STAT: local_rdata = STAT_VAL;
      IX_IFS:  local_rdata = {30'b0, ifsel_q};
      IX_SIM:  local_rdata = {31'b0, sim_q};
      IX_STBY: local_rdata = {31'b0, stdby_q};
      default: local_rdata = '0;
    endcase
  end

  assign core_sel   = bus_sel && (region != RG_LOCAL);
  assign core_wr    = bus_wr;
  assign core_size  = bus_size;
  assign core_wdata = bus_wdata;
  assign core_addr  = (region == RG_REMAP) ? remap_off(bus_addr) : bus_addr[CORE_AW-1:0];

  assign bus_err = bus_sel && (region == RG_LOCAL) && (!local_ok || ro_wr_evt);

  always_comb begin
    if (!bus_sel)            bus_rdata = '0;
    else if (core_sel)       bus_rdata = core_rdata;
    else if (local_ok)       bus_rdata = local_rdata;
    else                     bus_rdata = '0;
  end

  assign ctl_irq = core_irq;
endmodule

// File: rtl/usb_otg_regfront_chk.sv
module usb_otg_regfront_chk
  import usb_otg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [BUS_AW-1:0]  bus_addr,
  input logic [1:0]         bus_size,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_err,
  input logic               core_sel,
  input logic [CORE_AW-1:0] core_addr,
  input logic               soft_rst_evt,
  input logic [DATA_W-1:0]  cfg_q,
  input logic [1:0]         ifsel_q,
  input logic               sim_q,
  input logic               stdby_q
);
  assert_local_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr >= 12'h400) |-> !core_sel);

  assert_remap_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sel && bus_addr[11:9] == 3'b001) |->
      (core_addr[1:0] == 2'b00 && core_addr >= 9'h020 && core_addr <= 9'h05C));

  assert_ro_write_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_size == SZ_WORD &&
     (bus_addr == 12'h400 || bus_addr == 12'h408)) |-> bus_err);

  assert_cfg_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~CFG_KEEP) == '0);

  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_evt |=> (ifsel_q == 2'b00 && !sim_q && !stdby_q));

  assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_err) |-> bus_rdata == '0);

  assert_rejected_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_err) |=>
      ($stable(cfg_q) && $stable(ifsel_q) && $stable(sim_q) && $stable(stdby_q)));
endmodule

bind usb_otg_regfront usb_otg_regfront_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_size     (bus_size),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .core_sel     (core_sel),
  .core_addr    (core_addr),
  .soft_rst_evt (soft_rst_evt),
  .cfg_q        (cfg_q),
  .ifsel_q      (ifsel_q),
  .sim_q        (sim_q),
  .stdby_q      (stdby_q)
);

// File: tb/sim_usb_otg_regfront.sv
`timescale 1ns/1ps
module sim_usb_otg_regfront;
  localparam logic [31:0] REV = 32'hA5A5_0102;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, core_sel, core_wr;
  logic [1:0]  core_size;
  logic [8:0]  core_addr;
  logic [31:0] core_wdata, core_rdata;
  logic        core_irq = 1'b0, ctl_irq;

  int errors = 0, checks = 0;
  int m_cfg = 0, m_ifs = 0, m_sim = 0, m_stby = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign core_rdata = 32'hC0DE_0000 | {23'b0, core_addr};

  usb_otg_regfront #(.REV_VALUE(REV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .core_sel(core_sel),
    .core_wr(core_wr), .core_size(core_size), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_irq(core_irq),
    .ctl_irq(ctl_irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R10 compared on every clock
  always @(negedge clk) if (rst_n && !done) chk(ctl_irq == core_irq, "R10 irq", ctl_irq, core_irq);

  function automatic bit is_listed(input int a);
    return a == 'h400 || a == 'h404 || a == 'h408 || a == 'h40C || a == 'h410 || a == 'h414;
  endfunction

  task automatic acc(input bit wr, input int sz, input int a, input int wd, input string tag);
    int eaddr, erd; bit esel, eerr, ok_local;
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_size = 2'(sz); bus_addr = 12'(a); bus_wdata = wd;
    #1;
    esel = 0; eerr = 0; erd = 0; eaddr = 0; ok_local = 0;
    if (a < 'h200) begin esel = 1; eaddr = a; end
    else if (a < 'h400) begin esel = 1; eaddr = 32 + 4 * ((a / 32) % 16); end
    else begin
      ok_local = is_listed(a) && sz == 2;
      eerr = !ok_local || (wr && (a == 'h400 || a == 'h408));
      if (ok_local)
        case (a)
          'h400: erd = REV;
          'h404: erd = m_cfg;
          'h408: erd = 1;
          'h40C: erd = m_ifs;
          'h410: erd = m_sim;
          default: erd = m_stby;
        endcase
    end
    if (esel) erd = 'hC0DE0000 + eaddr;
    chk(core_sel == esel, {tag, " core_sel"}, core_sel, esel);
    chk(bus_err == eerr, {tag, " bus_err"}, bus_err, eerr);
    if (!wr) chk(bus_rdata == erd, {tag, " rdata"}, bus_rdata, erd);
    if (esel) begin
      chk(core_addr == eaddr, {tag, " core_addr"}, core_addr, eaddr);
      chk(core_wr == wr && core_size == sz && core_wdata == wd, {tag, " fwd"},
          {core_wr, core_size, core_wdata}, {wr, 2'(sz), wd});
    end
    @(posedge clk);
    if (wr && ok_local) begin
      if (a == 'h404) begin
        if (wd & 2) begin m_ifs = 0; m_sim = 0; m_stby = 0; end
        m_cfg = wd & 'h301D;
      end
      else if (a == 'h40C) m_ifs = wd & 3;
      else if (a == 'h410) m_sim = wd & 1;
      else if (a == 'h414) m_stby = wd & 1;
    end
    #1 bus_sel = 0;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset state
    acc(0, 2, 'h404, 0, "R11 cfg");
    acc(0, 2, 'h40C, 0, "R11 ifs");
    acc(0, 2, 'h410, 0, "R11 sim");
    acc(0, 2, 'h414, 0, "R11 stby");
    // R1 direct
    acc(0, 0, 'h000, 0, "R1 b0");
    acc(1, 1, 'h0A6, 'h1234, "R1 half wr");
    acc(1, 2, 'h1FC, 'hDEADBEEF, "R1 top");
    // R2 remap sweep
    for (int k = 0; k < 16; k++) acc(k % 2, 2, 'h200 + k * 32 + (k % 8), k, "R2 remap");
    acc(0, 2, 'h3FF, 0, "R2 end");
    // R4 read-only
    acc(0, 2, 'h400, 0, "R4 rev");
    acc(0, 2, 'h408, 0, "R4 stat");
    acc(1, 2, 'h400, -1, "R4 rev wr");
    acc(1, 2, 'h408, -1, "R4 stat wr");
    acc(0, 2, 'h400, 0, "R4 rev after");
    // R5/R6
    acc(1, 2, 'h404, 'hFFFFFFFD, "R5 cfg wr");
    acc(0, 2, 'h404, 0, "R5 cfg rd");
    acc(1, 2, 'h40C, 'hFFFFFFFF, "R6 ifs wr");
    acc(0, 2, 'h40C, 0, "R6 ifs rd");
    acc(1, 2, 'h410, 'hFFFFFFFF, "R6 sim wr");
    acc(1, 2, 'h414, 'h3, "R6 stby wr");
    acc(0, 2, 'h410, 0, "R6 sim rd");
    acc(0, 2, 'h414, 0, "R6 stby rd");
    // R8 unlisted
    acc(1, 2, 'h418, -1, "R8 418 wr");
    acc(1, 2, 'h40E, 0, "R8 unaligned wr");
    acc(0, 2, 'hFFC, 0, "R8 far rd");
    acc(0, 2, 'h40C, 0, "R8 ifs kept");
    // R9 narrow
    acc(1, 0, 'h40C, 0, "R9 byte wr");
    acc(1, 1, 'h410, 0, "R9 half wr");
    acc(0, 1, 'h400, 0, "R9 half rd");
    acc(0, 2, 'h40C, 0, "R9 ifs kept");
    acc(0, 2, 'h410, 0, "R9 sim kept");
    // R7 soft reset
    acc(1, 2, 'h404, 'h0000_1007, "R7 soft");
    acc(0, 2, 'h404, 0, "R7 cfg");
    acc(0, 2, 'h40C, 0, "R7 ifs");
    acc(0, 2, 'h410, 0, "R7 sim");
    acc(0, 2, 'h414, 0, "R7 stby");
    // R10 toggles
    for (int k = 0; k < 4; k++) begin @(negedge clk); core_irq = ~core_irq; end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule